// File: doc/BRIEF.md
# Ready/Busy Status Pin Controller

This block drives the single status pin of a flash-style memory from the activity of its internal write state machine. The pin either shows a plain ready/busy level or emits a short active-low pulse when a chosen kind of operation finishes. Firmware picks the behaviour by issuing a configuration write, and the low two data bits of that write select one of four modes.

Mode 0 is the reset default. In this mode the pin is high while the state machine is idle and low while it is busy. The other three modes keep the pin high and drop it low for a fixed time after an erase completes (mode 1), after a program completes (mode 2), or after either kind completes (mode 3). The low time is a parameter worked out from the clock period so that it lasts 500 ns.

A configuration write with any reserved bit set is rejected. It sets two status-register error flags, which stand for status bits 4 and 5, and these flags stay set until a clear-status strobe arrives.

Top module: `stspin_ctrl`

## Requirements
- R1: After reset the mode is 0, both error flags are 0, and the pin is high while `busy` is low.
- R2: In mode 0 the pin equals the inverse of `busy` as sampled at the previous clock edge. Completion events have no effect on the pin in this mode.
- R3: In mode 1 (`cfg_data[1:0]`=01) an `erase_done` pulse starts a low pulse on the pin, and `prog_done` alone leaves the pin high.
- R4: In mode 2 (`cfg_data[1:0]`=10) a `prog_done` pulse starts a low pulse on the pin, and `erase_done` alone leaves the pin high.
- R5: In mode 3 (`cfg_data[1:0]`=11) either completion event starts a low pulse.
- R6: A pulse is low for exactly PULSE_CYC = ceil(PULSE_NS/CLK_PERIOD_NS) cycles, which is 25 at the defaults (20 ns, 500 ns). It begins in the cycle after the event is sampled. Outside a pulse, the pin stays high in modes 1 to 3 whatever `busy` does.
- R7: A selected event that arrives during a pulse reloads the pulse length, so the pin stays low for PULSE_CYC cycles counted from that event.
- R8: The mode comes only from `cfg_data[1:0]`. A write with any of `cfg_data[7:2]` nonzero is invalid: it leaves the mode unchanged and sets both `err_sts4` and `err_sts5`.
- R9: The error flags hold their value until `clr_sts` is applied, which clears them. An invalid write in the same cycle as `clr_sts` leaves them set.
- R10: Every configuration write ends any pulse in progress, so the pin returns high in the next cycle if the new mode is a pulse mode. A configuration write takes priority over a completion event sampled at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration data; mode in [1:0], reserved bits in [7:2] |
| clr_sts | input | 1 | Clear-status strobe for the error flags |
| busy | input | 1 | Write state machine busy |
| erase_done | input | 1 | One-cycle erase completion event |
| prog_done | input | 1 | One-cycle program completion event |
| sts_pin | output | 1 | Status pin (level ready/busy, or active-low pulse) |
| err_sts4 | output | 1 | Status bit 4 error flag |
| err_sts5 | output | 1 | Status bit 5 error flag |

## Verification
The bench measures the exact length of a pulse. A counter that is off by one would give 24 or 26 low cycles. It then retriggers in the middle of a pulse, where a design that ignores the second event ends the pulse early.

It sends the wrong completion type in each pulse mode, which a design with a bad filter answers with a pulse. It also sets a reserved bit inside an otherwise valid code. A design that loads that code would switch mode, and one that loses the flags before the clear would report nothing.

It writes the configuration in the middle of a pulse, and it applies the clear and an invalid write in the same cycle. Wrong priority shows up as a pin left low or as flags that are cleared when they should stay set.

// File: rtl/stspin_pkg.sv
package stspin_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_ERASE = 2'b01,
    MODE_PROG  = 2'b10,
    MODE_ANY   = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/stspin_cfg.sv
module stspin_cfg
  import stspin_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             clr_sts,
  output pin_mode_e        mode,
  output logic             err
);
  logic      reject;
  pin_mode_e mode_d, mode_q;
  logic      err_d, err_q;

  always_comb begin
    reject = cfg_wr && (|cfg_data[CFG_W-1:2]);
    mode_d = mode_q;
    if (cfg_wr && !reject) mode_d = pin_mode_e'(cfg_data[1:0]);
    err_d = err_q;
    if (reject)       err_d = 1'b1;
    else if (clr_sts) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_LEVEL;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  assign mode = mode_q;
  assign err  = err_q;

  // R8: rejected write flags error and keeps the old mode
  p_reject_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && |cfg_data[CFG_W-1:2]) |=> err);
  p_reject_keeps_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && |cfg_data[CFG_W-1:2]) |=> $stable(mode));
  // R9: flags persist until cleared, and clear works
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr_sts) |=> err);
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sts && !(cfg_wr && |cfg_data[CFG_W-1:2])) |=> !err);
endmodule

// File: rtl/stspin_evsel.sv
module stspin_evsel
  import stspin_pkg::*;
(
  input  pin_mode_e mode,
  input  logic      erase_done,
  input  logic      prog_done,
  output logic      trig
);
  always_comb begin
    unique case (mode)
      MODE_ERASE: trig = erase_done;
      MODE_PROG:  trig = prog_done;
      MODE_ANY:   trig = erase_done | prog_done;
      default:    trig = 1'b0;
    endcase
  end
endmodule

// File: rtl/stspin_timer.sv
module stspin_timer #(
  parameter int PULSE_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic cancel,
  output logic active
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

  logic [CW-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (cancel)              cnt_d = '0;
    else if (trig)           cnt_d = LOAD;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // R7: an accepted trigger (re)loads the full length
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !cancel) |=> (cnt_q == LOAD));
  // R6: a running pulse counts down by one each cycle
  p_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !trig && !cancel) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R10: a cancel ends the pulse
  p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !active);
endmodule

// File: rtl/stspin_ctrl.sv
module stspin_ctrl
  import stspin_pkg::*;
#(
  parameter int CFG_W         = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int PULSE_NS      = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             clr_sts,
  input  logic             busy,
  input  logic             erase_done,
  input  logic             prog_done,
  output logic             sts_pin,
  output logic             err_sts4,
  output logic             err_sts5
);
  localparam int PULSE_CYC = (PULSE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       busy_q;
  logic       trig;
  logic       pulse_active;
  logic       err;
  pin_mode_e  mode;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) busy_q <= 1'b0;
    else            busy_q <= busy;
  end

  stspin_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg_wr   (cfg_wr),
    .cfg_data (cfg_data),
    .clr_sts  (clr_sts),
    .mode     (mode),
    .err      (err)
  );

  stspin_evsel u_evsel (
    .mode       (mode),
    .erase_done (erase_done),
    .prog_done  (prog_done),
    .trig       (trig)
  );

  stspin_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .trig   (trig),
    .cancel (cfg_wr),
    .active (pulse_active)
  );

  assign sts_pin  = (mode == MODE_LEVEL) ? ~busy_q : ~pulse_active;
  assign err_sts4 = err;
  assign err_sts5 = err;

  // R2 / R10: level mode never carries a pulse
  p_level_no_pulse_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == MODE_LEVEL) |-> !pulse_active);
  // R4: erase completion alone is filtered out in program mode
  p_prog_filter_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == MODE_PROG && erase_done && !prog_done && !cfg_wr && !pulse_active)
    |=> !pulse_active);
  // R3: program completion alone is filtered out in erase mode
  p_erase_filter_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == MODE_ERASE && prog_done && !erase_done && !cfg_wr && !pulse_active)
    |=> !pulse_active);
  // R5: either event fires in mode 3
  p_any_fires_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == MODE_ANY && (erase_done || prog_done) && !cfg_wr) |=> !sts_pin);
endmodule

// File: tb/stspin_ctrl_test.sv
module stspin_ctrl_test;
  localparam int PW = 25;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr, clr_sts, busy, erase_done, prog_done;
  logic [7:0] cfg_data;
  logic       sts_pin, err_sts4, err_sts5;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state, built from the requirements
  logic [1:0] m_mode;
  int         m_cnt;
  logic       m_busy, m_err;

  always #10 clk = ~clk;

  stspin_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .clr_sts(clr_sts), .busy(busy), .erase_done(erase_done),
    .prog_done(prog_done), .sts_pin(sts_pin), .err_sts4(err_sts4),
    .err_sts5(err_sts5)
  );

  function automatic logic sel(input logic [1:0] md, input logic e, input logic p);
    case (md)
      2'b01:   return e;
      2'b10:   return p;
      2'b11:   return e | p;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_pin();
    return (m_mode == 2'b00) ? ~m_busy : (m_cnt == 0);
  endfunction

  function automatic string mtag(input logic [1:0] md);
    case (md)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 2'b00; m_cnt = 0; m_busy = 1'b0; m_err = 1'b0;
    end else begin
      logic bad;
      bad = cfg_wr && (cfg_data[7:2] != 6'd0);
      if (cfg_wr) m_cnt = 0;
      else if (sel(m_mode, erase_done, prog_done)) m_cnt = PW;
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
      if (cfg_wr && !bad) m_mode = cfg_data[1:0];
      m_busy = busy;
      if (bad) m_err = 1'b1;
      else if (clr_sts) m_err = 1'b0;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check(mtag(m_mode), sts_pin, exp_pin());
    check("R9", err_sts4, m_err);
    check("R9", err_sts5, m_err);
  endtask

  task automatic idle();
    cfg_wr = 0; clr_sts = 0; erase_done = 0; prog_done = 0; cfg_data = 8'h00;
  endtask

  task automatic cfg(input logic [7:0] d);
    cfg_wr = 1; cfg_data = d; tick(); idle();
  endtask

  task automatic measure(output int n);
    n = 0;
    while (sts_pin == 1'b0 && n < 200) begin n++; tick(); end
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog: got hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    idle(); busy = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) tick();
    check("R1", sts_pin, 1'b1);
    check("R1", err_sts4 | err_sts5, 1'b0);

    // R2 level follows busy, events ignored
    busy = 1; tick(); check("R2", sts_pin, 1'b0);
    busy = 0; erase_done = 1; prog_done = 1; tick(); idle();
    check("R2", sts_pin, 1'b1);

    // R3 erase mode, wrong event filtered, exact width R6
    cfg(8'h01);
    busy = 1; prog_done = 1; tick(); idle();
    check("R3", sts_pin, 1'b1);
    erase_done = 1; tick(); idle();
    measure(n); check("R6", n == PW, 1'b1);
    busy = 0;

    // R7 retrigger after 10 low cycles
    erase_done = 1; tick(); idle();
    repeat (9) tick();
    erase_done = 1; tick(); idle();
    measure(n); check("R7", n == PW, 1'b1);

    // R8 reserved bit set: mode unchanged, flags set
    cfg(8'h06);
    check("R8", err_sts4 & err_sts5, 1'b1);
    prog_done = 1; tick(); idle();
    check("R8", sts_pin, 1'b1);
    // R9 clear and invalid in same cycle keeps flags
    clr_sts = 1; cfg_wr = 1; cfg_data = 8'h80; tick(); idle();
    check("R9", err_sts4, 1'b1);
    clr_sts = 1; tick(); idle();
    check("R9", err_sts4 | err_sts5, 1'b0);

    // R4 program mode
    cfg(8'h02);
    erase_done = 1; tick(); idle(); check("R4", sts_pin, 1'b1);
    prog_done = 1; tick(); idle(); check("R4", sts_pin, 1'b0);

    // R10 config write mid-pulse, same edge as event
    repeat (5) tick();
    cfg_wr = 1; cfg_data = 8'h03; prog_done = 1; tick(); idle();
    check("R10", sts_pin, 1'b1);
    // R5 both kinds fire
    erase_done = 1; tick(); idle(); check("R5", sts_pin, 1'b0);
    repeat (PW) tick();
    prog_done = 1; tick(); idle(); check("R5", sts_pin, 1'b0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 7) == 0) busy = ~busy;
      erase_done = ($urandom_range(0, 15) == 0);
      prog_done  = ($urandom_range(0, 15) == 0);
      clr_sts    = ($urandom_range(0, 29) == 0);
      cfg_wr     = ($urandom_range(0, 39) == 0);
      cfg_data   = ($urandom_range(0, 3) == 0) ? 8'($urandom)
                                               : {6'd0, 2'($urandom)};
      tick();
    end
    idle();
    tick();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule